// File: doc/BRIEF.md
# Eight-Level Nested Interrupt Priority Resolver

This block decides, every clock, whether a master interrupt controller should raise its interrupt line toward the processor, and which of its eight request inputs is presented. Input 0 ranks highest and input 7 lowest. Mask bits remove requests from consideration. The block keeps an in-service register. The winning input's bit is set in it when the processor acknowledges. A non-specific end-of-interrupt strobe retires the top-ranked level.

Two nesting policies are available, chosen by one mode input. In the normal nested policy, a level that is in service blocks itself and every lower level. The special nested policy is intended for a master whose inputs host cascaded slave controllers. In that policy a request on the very level already in service may interrupt again, so that a higher-ranked request inside that slave is not locked out. Lower levels stay blocked in both policies. The interrupt line and the presented index are registered.

Top module: `nested_prio_resolver`

## Requirements
- R1: During and right after synchronous reset, `int_o` is 0, `vec_o` is 0 and `isr_o` is 0.
- R2: With no unmasked request pending and the in-service register empty, `int_o` stays 0.
- R3: With the in-service register empty, the lowest-numbered unmasked pending input wins. One clock edge after the inputs are applied, `int_o` is 1 and `vec_o` holds its index as a 3-bit binary number.
- R4: A request whose bit in `mask_i` is 1 never raises `int_o` and is never presented on `vec_o`.
- R5: In both policies, a request on an input numbered higher than the lowest-numbered set bit of the in-service register does not raise `int_o`.
- R6: With `sfnm_i` = 0, a request on the input whose in-service bit is the lowest-numbered set bit does not raise `int_o`.
- R7: With `sfnm_i` = 1, a request on the input whose in-service bit is the lowest-numbered set bit raises `int_o`, and `vec_o` presents that input.
- R8: A cycle with `ack_i` = 1 while `int_o` = 1 sets bit `vec_o` of `isr_o` at the next edge. `ack_i` while `int_o` = 0 changes nothing.
- R9: A cycle with `eoi_i` = 1 clears only the lowest-numbered set bit of `isr_o` at the next edge.
- R10: `eoi_i` with an empty in-service register leaves `isr_o` at 0.
- R11: Whenever `int_o` is 0, `vec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Request lines, bit 0 highest priority |
| mask_i | input | 8 | 1 = corresponding request is masked |
| sfnm_i | input | 1 | 1 = special nested policy, 0 = normal nested |
| ack_i | input | 1 | Processor acknowledge; records presented winner as in service |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| int_o | output | 1 | Registered interrupt request to the processor |
| vec_o | output | 3 | Registered index of the presented input |
| isr_o | output | 8 | In-service register |

## Verification
A vector table runs the resolver with the in-service register empty. The patterns are: no requests, a lone highest input, a lone lowest input, two requests at once, and several masked combinations. Together they separate a correct priority search from a reversed one and show that a masked winner hands over to the next level. Directed sequences then acknowledge levels, so that the same request pattern is tried above, at, and below the in-service level under each policy. Only the equal-level case separates the two policies. The end-of-interrupt strobes are issued with two levels in service and then with none, which shows that only the top-ranked bit is retired and that an empty register stays empty.

// File: rtl/nested_prio_pkg.sv
package nested_prio_pkg;
  localparam int NLEV_DEF = 8;

  typedef enum logic {
    NEST_NORMAL  = 1'b0,
    NEST_SPECIAL = 1'b1
  } nest_mode_e;
endpackage

// File: rtl/prio_pick.sv
// Finds the lowest-numbered set bit (highest priority) of a vector.
module prio_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/nest_resolver.sv
// Compares the best pending request with the best in-service level.
module nest_resolver
  import nested_prio_pkg::*;
#(
  parameter int N  = NLEV_DEF,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  isr_i,
  input  nest_mode_e    mode_i,
  output logic          raise_o,
  output logic [IW-1:0] idx_o
);
  logic          p_any, s_any;
  logic [IW-1:0] p_idx, s_idx;

  prio_pick #(.N(N), .IW(IW)) u_pend_pick (
    .vec_i(pend_i), .any_o(p_any), .idx_o(p_idx)
  );

  prio_pick #(.N(N), .IW(IW)) u_isr_pick (
    .vec_i(isr_i), .any_o(s_any), .idx_o(s_idx)
  );

  always_comb begin
    raise_o = 1'b0;
    if (p_any) begin
      if (!s_any || (p_idx < s_idx)) raise_o = 1'b1;
      else if ((mode_i == NEST_SPECIAL) && (p_idx == s_idx)) raise_o = 1'b1;
    end
    idx_o = raise_o ? p_idx : '0;
  end
endmodule

// File: rtl/isr_track.sv
// In-service register: acknowledge sets a level, non-specific EOI clears the top one.
module isr_track #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_i,
  input  logic [IW-1:0] set_idx_i,
  input  logic          eoi_i,
  output logic [N-1:0]  isr_o
);
  logic [N-1:0] top_bit;
  logic [N-1:0] set_bit;

  assign top_bit = isr_o & (~isr_o + N'(1));
  assign set_bit = set_i ? (N'(1) << set_idx_i) : '0;

  always_ff @(posedge clk) begin
    if (rst) isr_o <= '0;
    else     isr_o <= (eoi_i ? (isr_o & ~top_bit) : isr_o) | set_bit;
  end

  // R10
  empty_eoi_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !set_i && (isr_o == '0)) |=> (isr_o == '0));

  // R9
  eoi_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !set_i && (isr_o != '0)) |=>
      (($countones(isr_o) + 1) == $countones($past(isr_o))) &&
      ((isr_o & ~$past(isr_o)) == '0));
endmodule

// File: rtl/nested_prio_resolver.sv
module nested_prio_resolver
  import nested_prio_pkg::*;
#(
  parameter int NLEV = NLEV_DEF,
  localparam int IW  = (NLEV > 1) ? $clog2(NLEV) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLEV-1:0] req_i,
  input  logic [NLEV-1:0] mask_i,
  input  logic            sfnm_i,
  input  logic            ack_i,
  input  logic            eoi_i,
  output logic            int_o,
  output logic [IW-1:0]   vec_o,
  output logic [NLEV-1:0] isr_o
);
  logic [NLEV-1:0] pend;
  logic            raise;
  logic [IW-1:0]   win_idx;
  nest_mode_e      mode;

  assign pend = req_i & ~mask_i;
  assign mode = nest_mode_e'(sfnm_i);

  nest_resolver #(.N(NLEV), .IW(IW)) u_resolve (
    .pend_i(pend), .isr_i(isr_o), .mode_i(mode),
    .raise_o(raise), .idx_o(win_idx)
  );

  isr_track #(.N(NLEV), .IW(IW)) u_isr (
    .clk(clk), .rst(rst),
    .set_i(ack_i && int_o), .set_idx_i(vec_o),
    .eoi_i(eoi_i), .isr_o(isr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_o <= 1'b0;
      vec_o <= '0;
    end else begin
      int_o <= raise;
      vec_o <= win_idx;
    end
  end

  // R4
  masked_win_chk: assert property (@(posedge clk) disable iff (rst)
    int_o |-> (($past(mask_i) & (NLEV'(1) << vec_o)) == '0));

  // R5
  lower_held_chk: assert property (@(posedge clk) disable iff (rst)
    int_o |-> (($past(isr_o) & ((NLEV'(1) << vec_o) - NLEV'(1))) == '0));

  // R6
  normal_block_chk: assert property (@(posedge clk) disable iff (rst)
    (int_o && !$past(sfnm_i)) |-> (($past(isr_o) & (NLEV'(1) << vec_o)) == '0));

  // R11
  idle_vec_chk: assert property (@(posedge clk) disable iff (rst)
    !int_o |-> (vec_o == '0));

  // R8
  ack_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && int_o && !eoi_i) |=> isr_o[$past(vec_o)]);
endmodule

// File: tb/test_nested_prio_resolver.sv
`timescale 1ns/1ps
module test_nested_prio_resolver;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] req_i, mask_i;
  logic       sfnm_i, ack_i, eoi_i;
  logic       int_o;
  logic [2:0] vec_o;
  logic [7:0] isr_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  nested_prio_resolver i_nested_prio_resolver (
    .clk(clk), .rst(rst), .req_i(req_i), .mask_i(mask_i), .sfnm_i(sfnm_i),
    .ack_i(ack_i), .eoi_i(eoi_i), .int_o(int_o), .vec_o(vec_o), .isr_o(isr_o)
  );

  // {req, mask, expected int, expected vec}, in-service register empty
  localparam logic [19:0] TBL [8] = '{
    {8'h00, 8'h00, 1'b0, 3'd0},
    {8'h01, 8'h00, 1'b1, 3'd0},
    {8'h80, 8'h00, 1'b1, 3'd7},
    {8'h90, 8'h00, 1'b1, 3'd4},
    {8'h90, 8'h10, 1'b1, 3'd7},
    {8'hFF, 8'hFF, 1'b0, 3'd0},
    {8'hFF, 8'h0F, 1'b1, 3'd4},
    {8'h06, 8'h02, 1'b1, 3'd2}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] r, input logic [7:0] m, input logic s);
    @(negedge clk);
    req_i = r; mask_i = m; sfnm_i = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_eoi();
    @(negedge clk); eoi_i = 1'b1;
    @(negedge clk); eoi_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; req_i = 8'hFF; mask_i = 8'h00; sfnm_i = 1'b0;
    ack_i = 1'b0; eoi_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 int", int_o, 0); chk("R1 vec", vec_o, 0); chk("R1 isr", isr_o, 0);
    req_i = 8'h00;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 int after release", int_o, 0);

    for (int i = 0; i < 8; i++) begin
      apply(TBL[i][19:12], TBL[i][11:4], 1'b0);
      chk($sformatf("R3/R4/R2 row %0d int", i), int_o, TBL[i][3]);
      chk($sformatf("R3/R11 row %0d vec", i), vec_o, TBL[i][2:0]);
    end

    // ack with int low is ignored (R8)
    apply(8'h00, 8'h00, 1'b0);
    pulse_ack();
    chk("R8 ack ignored", isr_o, 8'h00);

    // put level 5 in service
    apply(8'h20, 8'h00, 1'b0);
    chk("R3 level5", vec_o, 5);
    pulse_ack();
    chk("R8 isr set", isr_o, 8'h20);
    apply(8'h20, 8'h00, 1'b0);
    chk("R6 same level blocked", int_o, 0);
    chk("R11 vec zero", vec_o, 0);
    apply(8'h60, 8'h00, 1'b0);
    chk("R5 lower held normal", int_o, 0);
    apply(8'h20, 8'h00, 1'b1);
    chk("R7 same level raises", int_o, 1);
    chk("R7 vec", vec_o, 5);
    apply(8'h40, 8'h00, 1'b1);
    chk("R5 lower held special", int_o, 0);
    apply(8'h04, 8'h04, 1'b1);
    chk("R4 masked higher ignored", int_o, 0);
    apply(8'h24, 8'h00, 1'b0);
    chk("R3 higher nests int", int_o, 1);
    chk("R3 higher nests vec", vec_o, 2);
    pulse_ack();
    chk("R8 second level", isr_o, 8'h24);
    apply(8'h00, 8'h00, 1'b0);
    pulse_eoi();
    chk("R9 top cleared", isr_o, 8'h20);
    pulse_eoi();
    chk("R9 last cleared", isr_o, 8'h00);
    pulse_eoi();
    chk("R10 empty eoi", isr_o, 8'h00);
    apply(8'h80, 8'h00, 1'b0);
    chk("R10 state after empty eoi", vec_o, 7);

    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears int", int_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule